// File: doc/BRIEF.md
# CAN Loopback and Wake-Up Mode Control

This block is the mode-control front end that sits between a CAN protocol engine and the CAN transceiver pins. It holds a one-byte configuration register with three fields: a loopback enable, a wake-up filter mode and a clock source select. The register can only be changed while the controller is held in soft reset. From the loopback field it decides how the engine's transmit and receive bit lines connect to the pins. In normal operation the transmit bit goes straight to the pin and the pin comes back through a two-flop synchronizer. In loopback the engine hears its own transmit stream, the transmit pin stays recessive, and the acknowledge slot is forced dominant, so the node accepts its own frame.

While the sleep input is high, a small state machine watches the synchronized receive pin and raises a wake-up request. In edge mode any recessive-to-dominant transition wakes the controller. In filtered mode the bus must stay dominant for `DOM_MIN_CYCLES` consecutive clocks. The request stays latched until sleep is released. The clock-select output hands the chosen clock source to a clock switch outside this block.

The wake-up machine has four states. WK_IDLE means not sleeping. WK_ARMED means sleeping and waiting for a falling edge. WK_COUNT means filtered mode is timing a dominant pulse. WK_FIRED means the wake-up request is latched. Its transitions are:

- IDLE_TO_ARMED: sleep rises.
- ARMED_TO_FIRED: a falling edge in edge mode, or in filtered mode when `DOM_MIN_CYCLES` is 1.
- ARMED_TO_COUNT: a falling edge in filtered mode.
- COUNT_TO_ARMED: the bus returns to recessive.
- COUNT_TO_FIRED: the dominant count is reached.
- ANY_TO_IDLE: sleep falls.

Top module: `canfe_mode_ctl`

## Requirements
- R1: `cfg_rdata` always shows the register as {5'b00000, loopback, wake_mode, clk_src}: bit 2 is loopback, bit 1 is wake mode, bit 0 is clock source, and bits 7..3 read 0.
- R2: After reset `cfg_rdata` is 8'h00, `clk_sel` is 0, `wake_req` is 0 and `can_tx` follows `eng_tx`.
- R3: A cycle with `cfg_sel`=1 and `cfg_wr`=1 loads bits 2..0 of `cfg_wdata` into the register on the next clock edge, but only when `soft_rst`=1. When `soft_rst`=0 the write has no effect.
- R4: With loopback=0, `can_tx` equals `eng_tx`. `eng_rx` equals the value `can_rx` had two clock edges earlier.
- R5: With loopback=1, `can_tx` is 1 and `can_rx` has no effect on `eng_rx`. Outside the ack slot, `eng_rx` equals `eng_tx` in the same cycle.
- R6: With loopback=1 and `eng_ack_slot`=1, `eng_rx` is 0 whatever `eng_tx` is.
- R7: With wake mode 0 and sleep=1, a 1-to-0 transition of the synchronized `can_rx` sets `wake_req`, even when the dominant level lasts a single clock.
- R8: With wake mode 1 and sleep=1, `wake_req` sets only when `can_rx` stays 0 for `DOM_MIN_CYCLES` consecutive clocks. A shorter pulse does not set it. A return to 1 restarts the count, so two short pulses do not add up.
- R9: `wake_req` stays 1 while sleep stays 1. It falls one clock after sleep falls, and it never sets while sleep is 0.
- R10: `clk_sel` equals register bit 0: 0 selects the external oscillator clock and 1 selects the system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 1 | Register address decode hit |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data byte |
| cfg_rdata | output | 8 | Register readback |
| soft_rst | input | 1 | Soft-reset flag of the companion control register; enables writes |
| eng_tx | input | 1 | Transmit bit from the protocol engine |
| eng_ack_slot | input | 1 | Engine is in the acknowledge slot |
| eng_rx | output | 1 | Receive bit to the protocol engine |
| can_tx | output | 1 | Transmit pin (1 = recessive) |
| can_rx | input | 1 | Receive pin (asynchronous) |
| sleep | input | 1 | Controller is asleep; arms wake-up detection |
| wake_req | output | 1 | Latched wake-up request |
| clk_sel | output | 1 | Clock source select: 0 oscillator, 1 system clock |

## Verification
The assertions assume that `eng_ack_slot` is meaningful only during loopback. They also assume that `sleep` is a level held for many clocks rather than a glitch, and that `can_rx` may change at any time because the synchronizer absorbs it. The stimulus drives every input at the falling clock edge. It holds sleep for at least two clocks before any bus pulse, so the machine is in WK_ARMED before an edge arrives. It changes the register only through writes made while `soft_rst` is high, except for the deliberate blocked write.

// File: rtl/canfe_pkg.sv
package canfe_pkg;

    localparam int CFG_W     = 8;
    localparam int BIT_CLK   = 0;
    localparam int BIT_WMODE = 1;
    localparam int BIT_LOOP  = 2;

    typedef struct packed {
        logic loop_en;
        logic wake_mode;
        logic clk_src;
    } canfe_cfg_t;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_ARMED = 2'd1,
        WK_COUNT = 2'd2,
        WK_FIRED = 2'd3
    } canfe_wk_state_t;

endpackage

// File: rtl/canfe_cfg_reg.sv
module canfe_cfg_reg
    import canfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic             unlock,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output canfe_cfg_t       cfg
);

    canfe_cfg_t cfg_q;
    logic       wr_ok;

    // writes land only while the controller sits in soft reset
    assign wr_ok = sel & wr & unlock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_ok) begin
            cfg_q.loop_en   <= wdata[BIT_LOOP];
            cfg_q.wake_mode <= wdata[BIT_WMODE];
            cfg_q.clk_src   <= wdata[BIT_CLK];
        end
    end

    always_comb begin
        rdata            = '0;
        rdata[BIT_LOOP]  = cfg_q.loop_en;
        rdata[BIT_WMODE] = cfg_q.wake_mode;
        rdata[BIT_CLK]   = cfg_q.clk_src;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/canfe_sync.sv
module canfe_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[gi] <= RESET_VAL;
                    else        chain[gi] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[gi] <= RESET_VAL;
                    else        chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/canfe_bit_route.sv
module canfe_bit_route (
    input  logic loop_en,
    input  logic eng_tx,
    input  logic eng_ack_slot,
    input  logic rx_sync,
    output logic eng_rx,
    output logic can_tx
);

    always_comb begin
        if (loop_en) begin
            // pin held recessive, engine hears itself, ack slot forced dominant
            can_tx = 1'b1;
            eng_rx = eng_ack_slot ? 1'b0 : eng_tx;
        end else begin
            can_tx = eng_tx;
            eng_rx = rx_sync;
        end
    end

endmodule

// File: rtl/canfe_wake_fsm.sv
module canfe_wake_fsm
    import canfe_pkg::*;
#(
    parameter int DOM_MIN_CYCLES = 16,
    localparam int CNT_W = (DOM_MIN_CYCLES < 2) ? 1 : $clog2(DOM_MIN_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic wake_mode,
    input  logic bus_s,
    output logic wake_req
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DOM_MIN_CYCLES - 1);

    canfe_wk_state_t st_q, st_d;
    logic            bus_prev_q;
    logic            fall;
    logic [CNT_W-1:0] cnt_q;

    assign fall = bus_prev_q & ~bus_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_prev_q <= 1'b1;
        else        bus_prev_q <= bus_s;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WK_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WK_IDLE: begin
                if (sleep) st_d = WK_ARMED;
            end
            WK_ARMED: begin
                if (!sleep) begin
                    st_d = WK_IDLE;
                end else if (fall) begin
                    if (!wake_mode || DOM_MIN_CYCLES <= 1) st_d = WK_FIRED;
                    else                                   st_d = WK_COUNT;
                end
            end
            WK_COUNT: begin
                if (!sleep)               st_d = WK_IDLE;
                else if (bus_s)           st_d = WK_ARMED;
                else if (cnt_q >= CNT_LAST) st_d = WK_FIRED;
            end
            WK_FIRED: begin
                if (!sleep) st_d = WK_IDLE;
            end
            default: st_d = WK_IDLE;
        endcase
    end

    // dominant-length counter: first dominant sample counts as one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (st_d == WK_COUNT) begin
            if (st_q == WK_COUNT) cnt_q <= cnt_q + 1'b1;
            else                  cnt_q <= CNT_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            WK_FIRED: wake_req = 1'b1;
            default:  wake_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/canfe_mode_ctl.sv
module canfe_mode_ctl
    import canfe_pkg::*;
#(
    parameter int DOM_MIN_CYCLES = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_sel,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       soft_rst,
    input  logic       eng_tx,
    input  logic       eng_ack_slot,
    output logic       eng_rx,
    output logic       can_tx,
    input  logic       can_rx,
    input  logic       sleep,
    output logic       wake_req,
    output logic       clk_sel
);

    canfe_cfg_t cfg;
    logic       rx_s;

    canfe_cfg_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (cfg_sel),
        .wr     (cfg_wr),
        .unlock (soft_rst),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .cfg    (cfg)
    );

    canfe_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rx_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (can_rx),
        .q     (rx_s)
    );

    canfe_bit_route u_route (
        .loop_en      (cfg.loop_en),
        .eng_tx       (eng_tx),
        .eng_ack_slot (eng_ack_slot),
        .rx_sync      (rx_s),
        .eng_rx       (eng_rx),
        .can_tx       (can_tx)
    );

    canfe_wake_fsm #(.DOM_MIN_CYCLES(DOM_MIN_CYCLES)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .wake_mode (cfg.wake_mode),
        .bus_s     (rx_s),
        .wake_req  (wake_req)
    );

    assign clk_sel = cfg.clk_src;

endmodule

// File: rtl/canfe_mode_ctl_chk.sv
module canfe_mode_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic       soft_rst,
    input logic       eng_tx,
    input logic       eng_ack_slot,
    input logic       eng_rx,
    input logic       can_tx,
    input logic       sleep,
    input logic       wake_req,
    input logic       clk_sel
);

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7:3] == 5'd0);

    p_locked_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> $stable(cfg_rdata));

    p_loop_tx_recessive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[2] |-> can_tx);

    p_loop_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[2] && !eng_ack_slot) |-> (eng_rx == eng_tx));

    p_loop_ack_dom_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[2] && eng_ack_slot) |-> !eng_rx);

    p_wake_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && sleep) |=> wake_req);

    p_wake_needs_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |=> !wake_req);

    p_clksel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel == cfg_rdata[0]);

endmodule

bind canfe_mode_ctl canfe_mode_ctl_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_rdata    (cfg_rdata),
    .soft_rst     (soft_rst),
    .eng_tx       (eng_tx),
    .eng_ack_slot (eng_ack_slot),
    .eng_rx       (eng_rx),
    .can_tx       (can_tx),
    .sleep        (sleep),
    .wake_req     (wake_req),
    .clk_sel      (clk_sel)
);

// File: tb/test_canfe_mode_ctl.sv
module test_canfe_mode_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int DOM_MIN    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sel = 1'b0, cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       soft_rst = 1'b0;
    logic       eng_tx = 1'b1, eng_ack_slot = 1'b0;
    logic       eng_rx, can_tx;
    logic       can_rx = 1'b1;
    logic       sleep = 1'b0;
    logic       wake_req, clk_sel;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    canfe_mode_ctl #(.DOM_MIN_CYCLES(DOM_MIN)) i_canfe_mode_ctl (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .soft_rst(soft_rst),
        .eng_tx(eng_tx), .eng_ack_slot(eng_ack_slot), .eng_rx(eng_rx),
        .can_tx(can_tx), .can_rx(can_rx), .sleep(sleep),
        .wake_req(wake_req), .clk_sel(clk_sel)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] d, input logic unlock);
        @(negedge clk);
        soft_rst = unlock; cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_sel = 1'b0; cfg_wr = 1'b0; cfg_wdata = 8'h00; soft_rst = 1'b0;
    endtask

    task automatic t_reset;
        check("R2 rdata", cfg_rdata, 8'h00);
        check("R2 clk_sel", {7'd0, clk_sel}, 8'h00);
        check("R2 wake", {7'd0, wake_req}, 8'h00);
        eng_tx = 1'b0; #1;
        check("R2 tx follows", {7'd0, can_tx}, 8'h00);
        eng_tx = 1'b1;
    endtask

    task automatic t_write_gate;
        reg_write(8'hFF, 1'b1);
        check("R1 layout", cfg_rdata, 8'h07);
        reg_write(8'h00, 1'b0);
        check("R3 locked write ignored", cfg_rdata, 8'h07);
        reg_write(8'h02, 1'b1);
        check("R3 unlocked write", cfg_rdata, 8'h02);
        @(negedge clk);
        soft_rst = 1'b1; cfg_sel = 1'b0; cfg_wr = 1'b1; cfg_wdata = 8'h05;
        @(negedge clk);
        cfg_wr = 1'b0; soft_rst = 1'b0;
        check("R3 no sel no write", cfg_rdata, 8'h02);
        reg_write(8'h00, 1'b1);
    endtask

    task automatic t_clksel;
        reg_write(8'h01, 1'b1);
        check("R10 clk_sel sys", {7'd0, clk_sel}, 8'h01);
        reg_write(8'h00, 1'b1);
        check("R10 clk_sel osc", {7'd0, clk_sel}, 8'h00);
    endtask

    task automatic t_normal_path;
        eng_tx = 1'b0; #1;
        check("R4 tx pin low", {7'd0, can_tx}, 8'h00);
        eng_tx = 1'b1; #1;
        check("R4 tx pin high", {7'd0, can_tx}, 8'h01);
        @(negedge clk);
        can_rx = 1'b0;
        @(negedge clk);
        check("R4 rx one edge old", {7'd0, eng_rx}, 8'h01);
        @(negedge clk);
        check("R4 rx two edges", {7'd0, eng_rx}, 8'h00);
        can_rx = 1'b1;
        cycles(2);
        check("R4 rx back high", {7'd0, eng_rx}, 8'h01);
    endtask

    task automatic t_loopback;
        reg_write(8'h04, 1'b1);
        eng_tx = 1'b0; #1;
        check("R5 tx pin recessive", {7'd0, can_tx}, 8'h01);
        check("R5 echo low", {7'd0, eng_rx}, 8'h00);
        eng_tx = 1'b1; #1;
        check("R5 echo high", {7'd0, eng_rx}, 8'h01);
        can_rx = 1'b0;
        cycles(3);
        check("R5 rx pin ignored", {7'd0, eng_rx}, 8'h01);
        can_rx = 1'b1;
        eng_ack_slot = 1'b1; #1;
        check("R6 ack forced dominant", {7'd0, eng_rx}, 8'h00);
        eng_tx = 1'b0; #1;
        check("R6 ack with tx low", {7'd0, eng_rx}, 8'h00);
        eng_ack_slot = 1'b0; eng_tx = 1'b1; #1;
        check("R6 ack released", {7'd0, eng_rx}, 8'h01);
        cycles(3);
        reg_write(8'h00, 1'b1);
    endtask

    task automatic pulse_low(input int n);
        @(negedge clk);
        can_rx = 1'b0;
        cycles(n);
        can_rx = 1'b1;
    endtask

    task automatic t_wake_edge;
        reg_write(8'h00, 1'b1);
        pulse_low(1);
        cycles(6);
        check("R9 no wake awake", {7'd0, wake_req}, 8'h00);
        sleep = 1'b1;
        cycles(3);
        check("R7 armed no wake", {7'd0, wake_req}, 8'h00);
        pulse_low(1);
        cycles(4);
        check("R7 edge wakes", {7'd0, wake_req}, 8'h01);
        cycles(10);
        check("R9 wake held", {7'd0, wake_req}, 8'h01);
        sleep = 1'b0;
        @(negedge clk);
        check("R9 wake cleared", {7'd0, wake_req}, 8'h00);
    endtask

    task automatic t_wake_filter;
        reg_write(8'h02, 1'b1);
        sleep = 1'b1;
        cycles(3);
        pulse_low(DOM_MIN - 1);
        cycles(10);
        check("R8 short pulse rejected", {7'd0, wake_req}, 8'h00);
        pulse_low(5);
        cycles(1);
        pulse_low(5);
        cycles(10);
        check("R8 count restarts", {7'd0, wake_req}, 8'h00);
        pulse_low(DOM_MIN);
        cycles(10);
        check("R8 long pulse wakes", {7'd0, wake_req}, 8'h01);
        sleep = 1'b0;
        cycles(2);
        check("R9 filtered wake cleared", {7'd0, wake_req}, 8'h00);
        reg_write(8'h00, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_gate();
        t_clksel();
        t_normal_path();
        t_loopback();
        t_wake_edge();
        t_wake_filter();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule